// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single requests from an internal memory port into complete cycles on an external bus. The external bus has 16 address lines. The upper address byte has its own output pins. The lower address byte and the 8-bit data share one bidirectional path, which is split here into an output value, an output enable and an input value. Each access runs through fixed machine phases. T1 sends out the address under a short, active-low address strobe. T2 turns the shared path around for the data. T3 completes the access, and the active-low data strobe returns high at the end of T3.

Three controls set the length of an access. A configuration input adds two clocks to every access that starts while it is set. An active-low wait pin from the external device passes through a two-flop synchronizer and inserts wait phases (TW) before T3. A per-access wait budget limits how many wait phases can be inserted. When the budget runs out, the access is closed and the block reports a wait timeout.

On the internal side, a request is held until the block returns a one-clock acknowledge in T3. Read data is valid in the same cycle as the acknowledge. A new request is taken only after T3 has finished, so two accesses never overlap.

Top module: `xbus_mux_ctrl`

## Requirements
- R1: While reset is applied, and at the first sample after reset: both strobes and the data-memory select are high, the output enable is low, the read/write line is high (read) and acknowledge is low.
- R2: In the first cycle of an access (T1) the address strobe is low for exactly one cycle. During that cycle the shared path is driven with address bits 7..0, and the upper address pins carry bits 15..8. The upper pins do not change while the data strobe is low.
- R3: For the whole access the read/write line is 1 for a read and 0 for a write. The data-memory select is low when the request marks data memory and high otherwise. Neither line changes while the data strobe is low.
- R4: On a read, the output enable is low whenever the data strobe is low. The data strobe is low from T2 through T3. rdata_o at acknowledge equals the value on ad_i.
- R5: On a write, the write data is driven with the output enable from T2 through T3. The data strobe is low from the cycle after T2 through T3, which is one cycle shorter than on a read.
- R6: With no extension and no wait, an access lasts exactly 3 cycles from T1 to the acknowledge, counting both ends. The address strobe and the data strobe are never low in the same cycle.
- R7: When extended timing is set at acceptance, the access is exactly 2 cycles longer.
- R8: While the synchronized wait input is low, TW cycles are inserted before T3 with the data strobe held low. After the wait pin rises, T3 follows 3 cycles later: 2 synchronizer stages plus the decision edge.
- R9: No more wait cycles are inserted than the budget latched at acceptance. If the wait is still low when the budget is used up, T3 follows, and wait_err_o is high in the acknowledge cycle. A budget of 0 with wait low gives no TW and the error flag. wait_err_o is never high outside acknowledge.
- R10: Acknowledge lasts one cycle. If the request is still held after acknowledge, the next address strobe comes no earlier than the second cycle after the acknowledge.
- R11: A write access leaves rdata_o at the last value read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until ack_o |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_dm_i | input | 1 | 1 = data memory space |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 8 | Write data |
| ext_timing_i | input | 1 | Adds two clocks to the access |
| max_wait_i | input | 8 | Largest number of wait cycles allowed |
| ack_o | output | 1 | One-clock completion pulse in T3 |
| rdata_o | output | 8 | Read data, valid with ack_o |
| wait_err_o | output | 1 | Wait budget exceeded, shown with ack_o |
| addr_hi_o | output | 8 | Address bits 15..8 |
| ad_o | output | 8 | Value driven onto the shared address/data path |
| ad_oe_o | output | 1 | Drive enable for the shared path |
| ad_i | input | 8 | Value read from the shared path |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| rw_o | output | 1 | 1 = read, 0 = write |
| dm_n_o | output | 1 | Data-memory select, active low |
| wait_n_i | input | 1 | Asynchronous wait request, active low |

## Verification
A wrong phase shows at the strobes in the same cycle. An address strobe longer than one cycle, or overlapping the data strobe, shows at once, and so does an enabled driver while a read strobe is low. A wrong extension flag or wait counter changes the number of cycles to acknowledge. An off-by-one in the budget compare shows as an extra or missing TW cycle, or as a wrong error flag, at the acknowledge of that same access. A capture at the wrong time, or a capture taken on a write, shows on rdata_o at the acknowledge or at the next check after it.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TX1  = 3'd3,
    PH_TX2  = 3'd4,
    PH_TW   = 3'd5,
    PH_T3   = 3'd6
  } phase_e;

  // Phase after the data setup point: stretch while wait is low and budget remains.
  function automatic phase_e stall_or_finish(input logic wait_low, input logic budget_left);
    return (wait_low && budget_left) ? PH_TW : PH_T3;
  endfunction

  // A timeout happens when the access closes while wait is still asserted.
  function automatic logic timeout_hit(input logic wait_low, input logic budget_left);
    return wait_low && !budget_left;
  endfunction

  function automatic logic in_access(input phase_e ph);
    return ph != PH_IDLE;
  endfunction

  // Reads open the data strobe in T2; writes one phase later.
  function automatic logic ds_low(input phase_e ph, input logic is_read);
    case (ph)
      PH_T2:                        return is_read;
      PH_TX1, PH_TX2, PH_TW, PH_T3: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  // Address in T1 for all accesses, data from T2 onward only for writes.
  function automatic logic drives_bus(input phase_e ph, input logic is_write);
    case (ph)
      PH_T1:                               return 1'b1;
      PH_T2, PH_TX1, PH_TX2, PH_TW, PH_T3: return is_write;
      default:                             return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xbus_wait_sync.sv
module xbus_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n_i,
  output logic wait_low_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], wait_n_i};
  end

  assign wait_low_o = !sr[STAGES-1];
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              ext_i,
  input  logic              wait_low_i,
  input  logic [WAIT_W-1:0] max_wait_i,
  output phase_e            phase_o,
  output logic              accept_o,
  output logic              enter_t3_o,
  output logic              tmo_o,
  output logic [WAIT_W-1:0] wait_cnt_o,
  output logic [WAIT_W-1:0] wait_lim_o
);
  phase_e            phase, nxt;
  logic              ext_q, tmo_q, tmo_set, budget_left;
  logic [WAIT_W-1:0] cnt_q, lim_q;

  assign accept_o    = (phase == PH_IDLE) && req_i;
  assign budget_left = cnt_q < lim_q;

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE: nxt = req_i ? PH_T1 : PH_IDLE;
      PH_T1:   nxt = PH_T2;
      PH_T2:   nxt = ext_q ? PH_TX1 : stall_or_finish(wait_low_i, budget_left);
      PH_TX1:  nxt = PH_TX2;
      PH_TX2,
      PH_TW:   nxt = stall_or_finish(wait_low_i, budget_left);
      PH_T3:   nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  assign enter_t3_o = (nxt == PH_T3) && (phase != PH_T3);
  assign tmo_set    = enter_t3_o && timeout_hit(wait_low_i, budget_left);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      ext_q <= 1'b0;
      tmo_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      phase <= nxt;
      if (accept_o) begin
        ext_q <= ext_i;
        lim_q <= max_wait_i;
        cnt_q <= '0;
        tmo_q <= 1'b0;
      end else begin
        if (nxt == PH_TW) cnt_q <= cnt_q + 1'b1;
        if (tmo_set)      tmo_q <= 1'b1;
      end
    end
  end

  assign phase_o    = phase;
  assign tmo_o      = tmo_q;
  assign wait_cnt_o = cnt_q;
  assign wait_lim_o = lim_q;
endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_i,
  input  logic              accept_i,
  input  logic              enter_t3_i,
  input  logic              we_i,
  input  logic              dm_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              as_n_o,
  output logic              ds_n_o,
  output logic              rw_o,
  output logic              dm_n_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              we_q, dm_q, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      we_q    <= 1'b0;
      dm_q    <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        we_q    <= we_i;
        dm_q    <= dm_i;
      end
      if (enter_t3_i && !we_q) rdata_q <= ad_i;
    end
  end

  assign active    = in_access(phase_i);
  assign addr_hi_o = addr_q[ADDR_W-1:DATA_W];
  assign ad_o      = (phase_i == PH_T1) ? addr_q[DATA_W-1:0] : wdata_q;
  assign ad_oe_o   = drives_bus(phase_i, we_q);
  assign as_n_o    = !(phase_i == PH_T1);
  assign ds_n_o    = !ds_low(phase_i, !we_q);
  assign rw_o      = active ? !we_q : 1'b1;
  assign dm_n_o    = active ? !dm_q : 1'b1;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/xbus_mux_ctrl.sv
module xbus_mux_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int WAIT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic              req_dm_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              ext_timing_i,
  input  logic [WAIT_W-1:0] max_wait_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wait_err_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              as_n_o,
  output logic              ds_n_o,
  output logic              rw_o,
  output logic              dm_n_o,
  input  logic              wait_n_i
);
  phase_e            phase;
  logic              wait_low, accept, enter_t3, tmo;
  logic [WAIT_W-1:0] wait_cnt, wait_lim;

  xbus_wait_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .wait_n_i(wait_n_i), .wait_low_o(wait_low)
  );

  xbus_seq #(.WAIT_W(WAIT_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ext_i(ext_timing_i),
    .wait_low_i(wait_low), .max_wait_i(max_wait_i), .phase_o(phase),
    .accept_o(accept), .enter_t3_o(enter_t3), .tmo_o(tmo),
    .wait_cnt_o(wait_cnt), .wait_lim_o(wait_lim)
  );

  xbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .accept_i(accept),
    .enter_t3_i(enter_t3), .we_i(req_we_i), .dm_i(req_dm_i),
    .addr_i(req_addr_i), .wdata_i(req_wdata_i), .ad_i(ad_i),
    .addr_hi_o(addr_hi_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .as_n_o(as_n_o),
    .ds_n_o(ds_n_o), .rw_o(rw_o), .dm_n_o(dm_n_o), .rdata_o(rdata_o)
  );

  assign ack_o      = (phase == PH_T3);
  assign wait_err_o = ack_o && tmo;
endmodule

// File: rtl/xbus_mux_ctrl_chk.sv
module xbus_mux_ctrl_chk #(
  parameter int CNT_W = 8,
  parameter int HI_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             as_n,
  input logic             ds_n,
  input logic             rw,
  input logic             dm_n,
  input logic             ad_oe,
  input logic             ack,
  input logic             wait_err,
  input logic [HI_W-1:0]  addr_hi,
  input logic [CNT_W-1:0] wait_cnt,
  input logic [CNT_W-1:0] wait_lim
);
  AST_AS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) !as_n |=> as_n); // R2
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ds_n |-> $stable(addr_hi)); // R2
  AST_RW_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!ds_n && !$past(ds_n)) |-> ($stable(rw) && $stable(dm_n))); // R3
  AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n) (!ds_n && rw) |-> !ad_oe); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!as_n && !ds_n)); // R6
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) wait_cnt <= wait_lim); // R9
  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n) wait_err |-> ack); // R9
  AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n) ack |=> (!ack && as_n)); // R10
endmodule

bind xbus_mux_ctrl xbus_mux_ctrl_chk #(.CNT_W(WAIT_W), .HI_W(ADDR_W-DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n_o), .ds_n(ds_n_o), .rw(rw_o), .dm_n(dm_n_o),
  .ad_oe(ad_oe_o), .ack(ack_o), .wait_err(wait_err_o), .addr_hi(addr_hi_o),
  .wait_cnt(wait_cnt), .wait_lim(wait_lim)
);

// File: tb/test_xbus_mux_ctrl.sv
module test_xbus_mux_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic        dm;
    logic        ext;
    logic        wlow;
    logic [7:0]  max;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  xd;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'd4, 16'h12A5, 8'h00, 8'h3C},
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd4, 16'hBEEF, 8'h5A, 8'h00},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'd4, 16'h0F01, 8'h00, 8'hC3},
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd2, 16'hFF00, 8'hA7, 8'h00},
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd3, 16'h4321, 8'h00, 8'h99},
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'd2, 16'h8080, 8'h11, 8'h00},
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 16'h0000, 8'h00, 8'hFF},
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 16'hFFFF, 8'h6E, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, dm = 1'b0, ext = 1'b0, wait_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, max_wait = '0, ad_in = '0;
  logic        ack, wait_err, ad_oe, as_n, ds_n, rw, dm_n;
  logic [7:0]  rdata, addr_hi, ad_out;

  int checks = 0;
  int fails  = 0;
  logic [7:0] last_rd = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_mux_ctrl i_xbus_mux_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(we), .req_dm_i(dm),
    .req_addr_i(addr), .req_wdata_i(wdata), .ext_timing_i(ext), .max_wait_i(max_wait),
    .ack_o(ack), .rdata_o(rdata), .wait_err_o(wait_err), .addr_hi_o(addr_hi),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in), .as_n_o(as_n), .ds_n_o(ds_n),
    .rw_o(rw), .dm_n_o(dm_n), .wait_n_i(wait_n)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one access from a negedge; returns cycles to ack and per-cycle observations.
  task automatic run_access(input vec_t v, input logic keep_req,
                            output int n, output int ds_cnt, output int as_cnt,
                            output logic ctl_bad, output logic float_bad,
                            output logic t1_ok, output logic err, output logic [7:0] rd,
                            output logic wr_ok);
    we = v.we; dm = v.dm; ext = v.ext; max_wait = v.max;
    addr = v.addr; wdata = v.wd; ad_in = v.xd; req = 1'b1;
    n = 0; ds_cnt = 0; as_cnt = 0; ctl_bad = 0; float_bad = 0; t1_ok = 0;
    err = 0; rd = 0; wr_ok = 0;
    while (n < 100) begin
      @(negedge clk);
      n++;
      if (n == 1) t1_ok = !as_n && ad_oe && ad_out == v.addr[7:0] && addr_hi == v.addr[15:8];
      if (!as_n) as_cnt++;
      if (!ds_n) ds_cnt++;
      if (!ds_n && !v.we && ad_oe) float_bad = 1;
      if (rw != !v.we || dm_n != !v.dm || addr_hi != v.addr[15:8]) ctl_bad = 1;
      if (ack) begin
        err = wait_err; rd = rdata;
        wr_ok = ad_oe && ad_out == v.wd;
        break;
      end
    end
    if (!keep_req) req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, dsc, asc, exp_n;
    logic cb, fb, t1, er, wok;
    logic [7:0] rd;

    repeat (3) @(negedge clk);
    // R1 reset values
    chk(as_n && ds_n && dm_n && rw && !ad_oe && !ack, "R1 reset strobes",
        {as_n, ds_n, dm_n, rw, ad_oe, ack}, 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(as_n && ds_n && !ack && rdata == 8'h00, "R1 after reset", {as_n, ds_n, ack}, 3'b110);

    for (int i = 0; i < NVEC; i++) begin
      wait_n = !VECS[i].wlow;
      repeat (3) @(negedge clk);
      run_access(VECS[i], 1'b0, n, dsc, asc, cb, fb, t1, er, rd, wok);
      exp_n = 3 + (VECS[i].ext ? 2 : 0) + (VECS[i].wlow ? int'(VECS[i].max) : 0);
      chk(n == exp_n, VECS[i].ext ? "R7 extended length" :
                      (VECS[i].wlow ? "R9 wait-limited length" : "R6 base length"), n, exp_n);
      chk(t1, "R2 T1 address phase", {as_n, ad_out}, VECS[i].addr[7:0]);
      chk(asc == 1, "R2 single address strobe", asc, 1);
      chk(!cb, "R3 rw/dm/upper address held", cb, 0);
      chk(er == VECS[i].wlow, "R9 wait error flag", er, VECS[i].wlow);
      if (VECS[i].we) begin
        chk(dsc == exp_n - 2, "R5 write strobe width", dsc, exp_n - 2);
        chk(wok, "R5 write data driven at ack", ad_out, VECS[i].wd);
        chk(rd == last_rd, "R11 rdata kept across write", rd, last_rd);
      end else begin
        chk(dsc == exp_n - 1, "R4 read strobe width", dsc, exp_n - 1);
        chk(!fb, "R4 bus floated during read strobe", fb, 0);
        chk(rd == VECS[i].xd, "R4 read data at ack", rd, VECS[i].xd);
        last_rd = VECS[i].xd;
      end
      @(negedge clk);
      chk(!ack && !wait_err, "R10 ack one cycle", ack, 0);
    end

    // R8: wait released mid-access; T3 follows 3 cycles after release
    wait_n = 1'b0;
    repeat (3) @(negedge clk);
    we = 0; dm = 0; ext = 0; max_wait = 8'd20; addr = 16'h5A5A; ad_in = 8'h77; req = 1'b1;
    n = 0; dsc = 0;
    while (n < 100) begin
      @(negedge clk);
      n++;
      if (!ds_n) dsc++;
      if (n == 6) wait_n = 1'b1;
      if (ack) break;
    end
    req = 1'b0;
    chk(n == 9, "R8 wait release latency", n, 9);
    chk(dsc == 8, "R8 strobe held through wait", dsc, 8);
    chk(!wait_err && rdata == 8'h77, "R8 no error after release", {wait_err, rdata}, 9'h077);
    last_rd = 8'h77;
    @(negedge clk);

    // R10: request held across ack, next address strobe not before second cycle
    run_access(VECS[0], 1'b1, n, dsc, asc, cb, fb, t1, er, rd, wok);
    @(negedge clk);
    chk(as_n && !ack, "R10 idle cycle after ack", {as_n, ack}, 2'b10);
    @(negedge clk);
    chk(!as_n, "R10 next access starts", as_n, 0);
    req = 1'b0;
    n = 0;
    while (!ack && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(ack && rdata == VECS[0].xd, "R10 second access completes", rdata, VECS[0].xd);
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule